// File: doc/BRIEF.md
# Factorised Shift-Add Multiplier

This block multiplies two small unsigned operands without building a full partial-product array. Operand A is written relative to a fixed power of two, 2^K. The product is then the operand B shifted left by K bits, corrected by B times a small residual. When A is at or below the split, the residual is 2^K − A and the correction is subtracted. Above the split, the residual is A − 2^K and the correction is added.

The residual multiply is a short shift-add array. Its multiplier is only K+1 bits wide, because the residual never exceeds 2^K. The final correction uses a single parallel-prefix adder that also subtracts: the correction term is inverted and a carry-in is forced.

The block is purely combinational and has no clock. It is meant to sit between pipeline registers in a wider datapath. With the default K = 3, it takes two 4-bit operands and returns an 8-bit product.

Top module: `fmul_factor_mult`

## Requirements
- R1: For every pair of 4-bit unsigned operands, `prod` equals `op_a` × `op_b` as an 8-bit unsigned value.
- R2: For `op_a` from 1 to 7, the result is formed as (B·8) − B·(8 − A) and equals A·B.
- R3: For `op_a` from 9 to 15, the result is formed as (B·8) + B·(A − 8) and equals A·B.
- R4: The shifted term is B with K = 3 zero bits appended, so it equals B·8.
- R5: `op_a` = 0 takes the subtract branch with residual 8 and yields 0 for every B.
- R6: `op_a` = 8 gives residual 0, so `prod` equals exactly B·8.
- R7: A = 6, B = 5 gives 30, and A = 12, B = 10 gives 120.
- R8: The largest operands, A = 15 and B = 15, give 225 with no wrap. The prefix adder produces no borrow when subtracting and no carry out when adding.
- R9: `op_b` = 0 gives 0 for every A.
- R10: `prod` is a combinational function of the operands and is valid in the same cycle the operands change, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | K+1 (4) | Operand that is split around 2^K |
| op_b | input | K+1 (4) | Operand that is shifted and scaled |
| prod | output | 2K+2 (8) | Unsigned product |

## Verification
Every result is due in the same cycle as its operands, because the block holds no register. The driver applies a pair on a rising edge and queues the expected product. The monitor pops that entry at the following falling edge and compares it there, so each result is compared half a period after its stimulus. Because one entry is queued per edge and one is popped per falling edge, a stale or late product shows up as a mismatch. All 256 operand pairs are swept, and the named corner cases are then replayed under their own requirement tags.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

    // Default split exponent: the split point is 2**FM_K.
    localparam int unsigned FM_K = 3;

    // Which correction is applied to the shifted term.
    typedef enum logic {
        BR_SUB = 1'b0,
        BR_ADD = 1'b1
    } fmul_branch_e;

    function automatic int unsigned fm_opw(input int unsigned k);
        return k + 1;
    endfunction

    function automatic int unsigned fm_pw(input int unsigned k);
        return 2 * (k + 1);
    endfunction

endpackage

// File: rtl/fmul_factor.sv
module fmul_factor
    import fmul_pkg::*;
#(
    parameter int unsigned K = FM_K
) (
    input  logic [K:0]   a_in,
    output fmul_branch_e br,
    output logic [K:0]   resid
);
    // The split point 2**K, expressed in K+1 bits.
    localparam logic [K:0] SPLIT = {1'b1, {K{1'b0}}};

    always_comb begin
        if (a_in <= SPLIT) begin
            br    = BR_SUB;
            resid = SPLIT - a_in;
        end else begin
            br    = BR_ADD;
            resid = a_in - SPLIT;
        end
    end
endmodule

// File: rtl/fmul_shiftadd.sv
module fmul_shiftadd #(
    parameter int unsigned MW = 4,
    parameter int unsigned RW = 4,
    parameter int unsigned PW = 8
) (
    input  logic [MW-1:0] mcand,
    input  logic [RW-1:0] mplier,
    output logic [PW-1:0] prod
);
    logic [PW-1:0] row [RW];
    logic [PW-1:0] acc [RW+1];

    assign acc[0] = '0;

    // One shifted copy of the multiplicand for each residual bit, accumulated in turn.
    for (genvar i = 0; i < RW; i++) begin : g_row
        assign row[i]   = mplier[i] ? (PW'(mcand) << i) : '0;
        assign acc[i+1] = acc[i] + row[i];
    end

    assign prod = acc[RW];
endmodule

// File: rtl/fmul_prefix_addsub.sv
module fmul_prefix_addsub #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] x,
    input  logic [N-1:0] y,
    input  logic         sub,
    output logic [N-1:0] s,
    output logic         co
);
    localparam int unsigned LV = $clog2(N);

    logic [N-1:0] yy, p, g;
    logic [N-1:0] gl [LV+1];
    logic [N-1:0] pl [LV+1];

    // A subtraction inverts the second operand and forces a carry in.
    assign yy    = sub ? ~y : y;
    assign p     = x ^ yy;
    assign g     = x & yy;
    assign gl[0] = {g[N-1:1], g[0] | (p[0] & sub)};
    assign pl[0] = p;

    // Prefix tree: at each level a node combines with the node 2**lvl positions below it.
    for (genvar lvl = 0; lvl < LV; lvl++) begin : g_lvl
        for (genvar i = 0; i < N; i++) begin : g_bit
            if (i >= (1 << lvl)) begin : g_node
                assign gl[lvl+1][i] = gl[lvl][i] | (pl[lvl][i] & gl[lvl][i-(1<<lvl)]);
                assign pl[lvl+1][i] = pl[lvl][i] & pl[lvl][i-(1<<lvl)];
            end else begin : g_pass
                assign gl[lvl+1][i] = gl[lvl][i];
                assign pl[lvl+1][i] = pl[lvl][i];
            end
        end
    end

    assign s[0] = p[0] ^ sub;
    for (genvar i = 1; i < N; i++) begin : g_sum
        assign s[i] = p[i] ^ gl[LV][i-1];
    end

    assign co = gl[LV][N-1];
endmodule

// File: rtl/fmul_factor_mult.sv
module fmul_factor_mult
    import fmul_pkg::*;
#(
    parameter int unsigned K = FM_K
) (
    input  logic [K:0]     op_a,
    input  logic [K:0]     op_b,
    output logic [2*K+1:0] prod
);
    localparam int unsigned W  = fm_opw(K);
    localparam int unsigned PW = fm_pw(K);

    fmul_branch_e  br;
    logic [K:0]    resid;
    logic [PW-1:0] shifted;
    logic [PW-1:0] res_prod;
    logic          carry_out;

    fmul_factor #(.K(K)) u_factor (
        .a_in  (op_a),
        .br    (br),
        .resid (resid)
    );

    // B followed by K zero bits, zero-extended to the product width.
    assign shifted = {1'b0, op_b, {K{1'b0}}};

    fmul_shiftadd #(.MW(W), .RW(K+1), .PW(PW)) u_resmul (
        .mcand  (op_b),
        .mplier (resid),
        .prod   (res_prod)
    );

    fmul_prefix_addsub #(.N(PW)) u_adder (
        .x   (shifted),
        .y   (res_prod),
        .sub (br == BR_SUB),
        .s   (prod),
        .co  (carry_out)
    );
endmodule

// File: rtl/fmul_chk.sv
module fmul_chk
    import fmul_pkg::*;
#(
    parameter int unsigned K = FM_K
) (
    input logic [K:0]     op_a,
    input logic [K:0]     op_b,
    input logic [2*K+1:0] prod,
    input fmul_branch_e   br,
    input logic [K:0]     resid,
    input logic [2*K+1:0] res_prod,
    input logic           carry_out
);
    localparam int SPLIT = 1 << K;

    always_comb begin
        // R1
        prod_exact_chk: assert (int'(prod) == int'(op_a) * int'(op_b))
            else $error("prod %0d for %0d*%0d", prod, op_a, op_b);
        // R2
        branch_sel_chk: assert ((int'(op_a) <= SPLIT) == (br == BR_SUB))
            else $error("branch wrong for a=%0d", op_a);
        // R3
        resid_range_chk: assert ((br == BR_SUB) ? (int'(resid) <= SPLIT) : (int'(resid) < SPLIT))
            else $error("residual %0d out of range", resid);
        // R2
        resid_prod_chk: assert (int'(res_prod) == int'(op_b) * int'(resid))
            else $error("residual product %0d", res_prod);
        // R5
        zero_a_chk: assert (op_a != '0 || prod == '0)
            else $error("a=0 gave %0d", prod);
        // R8
        no_overflow_chk: assert (carry_out == (br == BR_SUB))
            else $error("carry/borrow out of adder");
    end
endmodule

bind fmul_factor_mult fmul_chk #(.K(K)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .prod      (prod),
    .br        (br),
    .resid     (resid),
    .res_prod  (res_prod),
    .carry_out (carry_out)
);

// File: tb/test_fmul_factor_mult.sv
module test_fmul_factor_mult;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_a = '0;
    logic [3:0] op_b = '0;
    logic [7:0] prod;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        int    exp;
        int    a;
        int    b;
        string tag;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    fmul_factor_mult i_fmul_factor_mult (
        .op_a (op_a),
        .op_b (op_b),
        .prod (prod)
    );

    task automatic drive(input int a, input int b, input string tag);
        item_t it;
        @(posedge clk);
        op_a <= 4'(a);
        op_b <= 4'(b);
        it.exp = a * b;
        it.a   = a;
        it.b   = b;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // R10: each result is compared at the falling edge of the cycle its operands were applied.
    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (int'(prod) != it.exp) begin
                errors++;
                $display("FAIL %s (R1,R10): a=%0d b=%0d actual=%0d expected=%0d",
                         it.tag, it.a, it.b, prod, it.exp);
            end
        end
    end

    function automatic string tag_for(input int a, input int b);
        if (b == 0)  return "R9";
        if (a == 0)  return "R5";
        if (a == 8)  return "R6";
        if (a < 8)   return "R2";
        return "R3";
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        // Reset-time check: the block holds no state, so zero operands must give zero.
        @(negedge clk);
        checks++;
        if (prod != 8'd0) begin
            errors++;
            $display("FAIL R1 reset: actual=%0d expected=0", prod);
        end
        rst = 1'b0;

        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                drive(a, b, tag_for(a, b));

        // R4 and R6: with A at the split, the product is the shifted term alone.
        for (int b = 0; b < 16; b++) drive(8, b, "R4");
        drive(6, 5, "R7");
        drive(12, 10, "R7");
        drive(15, 15, "R8");
        drive(0, 15, "R5");
        drive(15, 0, "R9");
        // R10: consecutive changes every cycle, back to back.
        drive(1, 1, "R10");
        drive(7, 9, "R10");
        drive(9, 7, "R10");

        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R10: %0d results never compared, expected 0", sb_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule